// File: doc/BRIEF.md
# Thread Block Admission Controller

This block sits in front of one multiprocessor core and decides, one descriptor at a time, whether an incoming thread block may become resident. A descriptor carries a block identifier and a thread count and is offered through a valid/ready handshake. A block is admitted whole or not at all. It is admitted only when a block slot is free and the resident thread total plus the new block's threads stays within the core's thread capacity.

Each admitted block takes the lowest free slot. The slot number is returned with the grant and the slot remembers the block's thread count. When the core finishes a block, it pulses a completion with that slot number. The slot is then released and the block's threads and warps are taken off the totals in the same cycle. A descriptor that fits later is held off with ready low. A descriptor that can never fit has a thread count of zero, above the per-block maximum or above the core capacity. It is accepted at once with an error flag and dropped.

Top module: `blk_admit_ctrl`

## Requirements
- R1: After reset the resident block, thread and warp counts are 0 and `req_ready` is low while `req_valid` is low.
- R2: A legal descriptor that fits is accepted in the cycle it is offered, with `req_ready` and `grant_valid` high and `grant_id` equal to `req_id`. The block, thread and warp totals show the new block from the next cycle.
- R3: A legal descriptor whose threads would push the resident total above 768 sees `req_ready` low and changes no count.
- R4: At most 8 blocks are resident. With 8 resident, a further legal descriptor waits with `req_ready` low, even when threads remain (8 blocks of 64 hold 512 threads).
- R5: A thread count of 0, or above 512, is accepted with `req_ready` high, `req_err` high and `grant_valid` low, and leaves every count unchanged.
- R6: A completion on an occupied slot frees that slot and subtracts its thread and warp counts from the next cycle on. A completion on a free slot has no effect.
- R7: An admission and a completion in the same cycle both take effect. The block count is unchanged and the thread total moves by the difference.
- R8: The resident warp count is the sum over resident blocks of the thread count divided by 32, rounded up. For example, 3 blocks of 256 give 24, a block of 33 gives 2, and a block of 1 gives 1.
- R9: `grant_slot` is the lowest-numbered free slot, counting from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Descriptor offered |
| req_id | input | 8 | Block identifier of the descriptor |
| req_threads | input | 11 | Thread count of the descriptor |
| req_ready | output | 1 | Descriptor taken this cycle (admitted or dropped) |
| req_err | output | 1 | Descriptor can never fit and is being dropped |
| grant_valid | output | 1 | Descriptor admitted this cycle |
| grant_slot | output | 3 | Slot assigned to the admitted block |
| grant_id | output | 8 | Identifier of the admitted block |
| done_valid | input | 1 | Completion pulse |
| done_slot | input | 3 | Slot of the finished block |
| res_blocks | output | 4 | Resident block count |
| res_threads | output | 10 | Resident thread total |
| res_warps | output | 5 | Resident warp total |

## Verification
Some properties are checked by the assertions on every cycle:
- the block and thread ceilings;
- that a grant is always a clean handshake and never an error;
- that a dropped descriptor leaves the totals alone;
- how the block count moves on a completion with or without a simultaneous admission;
- that an empty core holds no threads or warps.

Other behaviour only the directed scenarios can show:
- which slot is picked;
- exact thread and warp totals under specific block mixes, including rounding;
- a waiting descriptor being released by a completion;
- that a completion on a free slot is ignored.

// File: rtl/bac_pkg.sv
package bac_pkg;
  // warps needed for a block: ceiling of threads over warp size
  function automatic int unsigned warps_of(input int unsigned thr, input int unsigned wsz);
    return (thr + wsz - 1) / wsz;
  endfunction

  // a request can never become resident
  function automatic bit never_fits(input int unsigned thr, input int unsigned blk_max,
                                    input int unsigned core_max);
    return (thr == 0) || (thr > blk_max) || (thr > core_max);
  endfunction

  // thread budget allows the request now
  function automatic bit room_for(input int unsigned cur, input int unsigned add,
                                  input int unsigned core_max);
    return (cur + add) <= core_max;
  endfunction
endpackage

// File: rtl/bac_slot_table.sv
module bac_slot_table #(
  parameter int unsigned N_SLOT = 8,
  parameter int unsigned TW     = 10,
  parameter int unsigned SW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic [TW-1:0] alloc_thr,
  input  logic          rel_req,
  input  logic [SW-1:0] rel_slot,
  output logic          any_free,
  output logic [SW-1:0] free_idx,
  output logic          rel_hit,
  output logic [TW-1:0] rel_thr
);
  logic [N_SLOT-1:0] occ_q;
  logic [TW-1:0]     thr_q [N_SLOT];
  logic              slot_ok;

  // lowest free slot wins
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N_SLOT - 1; i >= 0; i--) begin
      if (!occ_q[i]) begin
        any_free = 1'b1;
        free_idx = SW'(i);
      end
    end
  end

  assign slot_ok = (32'(rel_slot) < N_SLOT);
  assign rel_hit = rel_req && slot_ok && occ_q[slot_ok ? rel_slot : '0];
  assign rel_thr = rel_hit ? thr_q[rel_slot] : '0;

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ_q[g] <= 1'b0;
        thr_q[g] <= '0;
      end else if (alloc_en && free_idx == SW'(g)) begin
        occ_q[g] <= 1'b1;
        thr_q[g] <= alloc_thr;
      end else if (rel_hit && rel_slot == SW'(g)) begin
        occ_q[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bac_fit_check.sv
module bac_fit_check #(
  parameter int unsigned BLK_MAX  = 512,
  parameter int unsigned CORE_MAX = 768,
  parameter int unsigned IW       = 11,
  parameter int unsigned TW       = 10
) (
  input  logic          valid,
  input  logic [IW-1:0] thr,
  input  logic [TW-1:0] cur_thr,
  input  logic          slot_free,
  output logic          bad,
  output logic          fits
);
  import bac_pkg::*;
  assign bad  = valid && never_fits(32'(thr), BLK_MAX, CORE_MAX);
  assign fits = valid && !bad && slot_free && room_for(32'(cur_thr), 32'(thr), CORE_MAX);
endmodule

// File: rtl/blk_admit_ctrl.sv
module blk_admit_ctrl #(
  parameter int unsigned MAX_BLOCKS  = 8,
  parameter int unsigned MAX_THREADS = 768,
  parameter int unsigned BLK_THREADS = 512,
  parameter int unsigned WARP_SIZE   = 32,
  parameter int unsigned ID_W        = 8,
  parameter int unsigned REQ_W       = 11,
  localparam int unsigned SLOT_W = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1,
  localparam int unsigned BCNT_W = $clog2(MAX_BLOCKS + 1),
  localparam int unsigned THR_W  = $clog2(MAX_THREADS + 1),
  localparam int unsigned WRP_W  = $clog2(MAX_THREADS / WARP_SIZE + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic [REQ_W-1:0]  req_threads,
  output logic              req_ready,
  output logic              req_err,
  output logic              grant_valid,
  output logic [SLOT_W-1:0] grant_slot,
  output logic [ID_W-1:0]   grant_id,
  input  logic              done_valid,
  input  logic [SLOT_W-1:0] done_slot,
  output logic [BCNT_W-1:0] res_blocks,
  output logic [THR_W-1:0]  res_threads,
  output logic [WRP_W-1:0]  res_warps
);
  import bac_pkg::*;

  // named internal events
  logic             slot_free;
  logic [SLOT_W-1:0] first_free;
  logic             done_hit;
  logic [THR_W-1:0] done_thr;
  logic             bad_req;
  logic             fit_req;
  logic             admit;
  logic [THR_W-1:0] adm_thr;
  logic [WRP_W-1:0] adm_wrp;
  logic [WRP_W-1:0] done_wrp;

  bac_fit_check #(
    .BLK_MAX(BLK_THREADS), .CORE_MAX(MAX_THREADS), .IW(REQ_W), .TW(THR_W)
  ) u_fit (
    .valid(req_valid), .thr(req_threads), .cur_thr(res_threads),
    .slot_free(slot_free), .bad(bad_req), .fits(fit_req)
  );

  assign admit   = fit_req;
  assign adm_thr = admit ? THR_W'(req_threads) : '0;

  bac_slot_table #(.N_SLOT(MAX_BLOCKS), .TW(THR_W), .SW(SLOT_W)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(admit), .alloc_thr(adm_thr),
    .rel_req(done_valid), .rel_slot(done_slot),
    .any_free(slot_free), .free_idx(first_free),
    .rel_hit(done_hit), .rel_thr(done_thr)
  );

  assign adm_wrp  = admit    ? WRP_W'(warps_of(32'(adm_thr), WARP_SIZE))  : '0;
  assign done_wrp = done_hit ? WRP_W'(warps_of(32'(done_thr), WARP_SIZE)) : '0;

  assign req_ready   = bad_req || fit_req;
  assign req_err     = bad_req;
  assign grant_valid = admit;
  assign grant_slot  = first_free;
  assign grant_id    = req_id;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_blocks  <= '0;
      res_threads <= '0;
      res_warps   <= '0;
    end else begin
      res_blocks  <= res_blocks + BCNT_W'(admit) - BCNT_W'(done_hit);
      res_threads <= res_threads + adm_thr - done_thr;
      res_warps   <= res_warps + adm_wrp - done_wrp;
    end
  end
endmodule

// File: rtl/bac_chk.sv
module bac_chk #(
  parameter int unsigned MAX_BLOCKS  = 8,
  parameter int unsigned MAX_THREADS = 768,
  parameter int unsigned BW = 4,
  parameter int unsigned TW = 10,
  parameter int unsigned WW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_err,
  input logic          grant_valid,
  input logic          done_hit,
  input logic [BW-1:0] res_blocks,
  input logic [TW-1:0] res_threads,
  input logic [WW-1:0] res_warps
);
  a_r1_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !req_ready);
  a_r2_grant_is_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (req_valid && req_ready && !req_err));
  a_r3_thread_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    32'(res_threads) <= MAX_THREADS);
  a_r4_block_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    32'(res_blocks) <= MAX_BLOCKS);
  a_r5_drop_keeps_totals: assert property (@(posedge clk) disable iff (!rst_n)
    (req_err && !done_hit) |=> ($stable(res_threads) && $stable(res_blocks) && $stable(res_warps)));
  a_r6_release_drops_block: assert property (@(posedge clk) disable iff (!rst_n)
    (done_hit && !grant_valid) |=> (res_blocks == $past(res_blocks) - BW'(1)));
  a_r7_swap_keeps_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (done_hit && grant_valid) |=> $stable(res_blocks));
  a_r8_empty_core: assert property (@(posedge clk) disable iff (!rst_n)
    (res_blocks == '0) |-> (res_threads == '0 && res_warps == '0));
endmodule

bind blk_admit_ctrl bac_chk #(
  .MAX_BLOCKS(MAX_BLOCKS), .MAX_THREADS(MAX_THREADS),
  .BW(BCNT_W), .TW(THR_W), .WW(WRP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_err(req_err), .grant_valid(grant_valid), .done_hit(done_hit),
  .res_blocks(res_blocks), .res_threads(res_threads), .res_warps(res_warps)
);

// File: tb/sim_blk_admit_ctrl.sv
module sim_blk_admit_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_id = '0;
  logic [10:0] req_threads = '0;
  logic        req_ready, req_err, grant_valid;
  logic [2:0]  grant_slot;
  logic [7:0]  grant_id;
  logic        done_valid = 1'b0;
  logic [2:0]  done_slot = '0;
  logic [3:0]  res_blocks;
  logic [9:0]  res_threads;
  logic [4:0]  res_warps;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_admit_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_threads(req_threads), .req_ready(req_ready), .req_err(req_err),
    .grant_valid(grant_valid), .grant_slot(grant_slot), .grant_id(grant_id),
    .done_valid(done_valid), .done_slot(done_slot),
    .res_blocks(res_blocks), .res_threads(res_threads), .res_warps(res_warps)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; done_valid = 1'b0;
    step();
    rst_n = 1'b1;
  endtask

  task automatic check_totals(input string req, input int b, input int t, input int w);
    check({req, " blocks"}, int'(res_blocks), b);
    check({req, " threads"}, int'(res_threads), t);
    check({req, " warps"}, int'(res_warps), w);
  endtask

  // offer one descriptor for one cycle and check the same-cycle response
  task automatic offer(input int thr, input int id, input int exp_ready,
                       input int exp_grant, input int exp_slot, input string req);
    req_valid = 1'b1; req_threads = 11'(thr); req_id = 8'(id);
    #1;
    check({req, " ready"}, int'(req_ready), exp_ready);
    check({req, " grant"}, int'(grant_valid), exp_grant);
    if (exp_grant != 0) begin
      check({req, " slot"}, int'(grant_slot), exp_slot);
      check({req, " id"}, int'(grant_id), id);
    end
    step();
    req_valid = 1'b0;
  endtask

  task automatic finish(input int slot);
    done_valid = 1'b1; done_slot = 3'(slot);
    step();
    done_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check("R1 ready idle", int'(req_ready), 0);
    check_totals("R1", 0, 0, 0);
  endtask

  task automatic t_thread_cap();
    do_reset();
    for (int i = 0; i < 3; i++) offer(256, 10 + i, 1, 1, i, "R2 R9 fill256");
    #1;
    check_totals("R8 3x256", 3, 768, 24);
    offer(32, 20, 0, 0, 0, "R3 over cap");
    #1;
    check_totals("R3 unchanged", 3, 768, 24);
    finish(1);
    check_totals("R6 release slot1", 2, 512, 16);
    offer(32, 21, 1, 1, 1, "R9 reuse slot1");
    check_totals("R2 after 32", 3, 544, 17);
  endtask

  task automatic t_slot_cap();
    do_reset();
    for (int i = 0; i < 8; i++) offer(64, 30 + i, 1, 1, i, "R4 fill64");
    check_totals("R4 8x64", 8, 512, 16);
    offer(64, 40, 0, 0, 0, "R4 ninth waits");
    check_totals("R4 unchanged", 8, 512, 16);
    finish(7);
    check_totals("R6 release slot7", 7, 448, 14);
    // simultaneous release of slot 0 and admit of 96 threads into slot 7
    done_valid = 1'b1; done_slot = 3'd0;
    offer(96, 41, 1, 1, 7, "R7 swap");
    done_valid = 1'b0;
    check_totals("R7 swap", 7, 448 - 64 + 96, 14 - 2 + 3);
  endtask

  task automatic t_illegal();
    do_reset();
    offer(100, 50, 1, 1, 0, "R2 base");
    req_valid = 1'b1; req_threads = 11'd0;
    #1;
    check("R5 zero err", int'(req_err), 1);
    step();
    req_valid = 1'b0;
    offer(513, 51, 1, 0, 0, "R5 513 dropped");
    offer(1024, 52, 1, 0, 0, "R5 1024 dropped");
    check_totals("R5 unchanged", 1, 100, 4);
    offer(512, 53, 1, 1, 1, "R5 512 legal");
    check_totals("R5 after 512", 2, 612, 20);
  endtask

  task automatic t_rounding();
    do_reset();
    offer(33, 60, 1, 1, 0, "R8 33");
    check_totals("R8 33", 1, 33, 2);
    offer(1, 61, 1, 1, 1, "R8 1");
    check_totals("R8 plus 1", 2, 34, 3);
    finish(5);
    check_totals("R6 empty slot ignored", 2, 34, 3);
    finish(0);
    check_totals("R6 release 33", 1, 1, 1);
    offer(200, 62, 1, 1, 0, "R9 slot0 again");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_thread_cap();
        t_slot_cap();
        t_illegal();
        t_rounding();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule